// File: doc/BRIEF.md
# Standby Mode Power Controller

This block puts a small microcontroller into one of two low-power modes and brings it back out. In the light mode the CPU clock is gated at the next instruction boundary while the peripheral clock keeps running. In the deep mode every clock is gated. The main oscillator can be shut down as an option, and the output ports can be floated as an option. Software writes a control byte to request either mode. The deep mode is accepted only if a two-write unlock code has gone to a separate code port just before.

Wake-up comes from a reset request (the external pin or a watchdog overflow), a non-maskable interrupt, or a maskable interrupt whose request and enable are both set. The block reports the wake with a one-cycle strobe and a code. The code tells the core to run reset processing, to service the interrupt, or to resume at the next instruction. If the oscillator was stopped, the clocks stay gated for a selectable stabilization delay after wake before they are released.

Top module: `standby_ctl`

## Requirements
- R1: A control write with bit 1 set, made while running, keeps `cpu_clk_en` at 1 until the next `insn_bnd` pulse. After that pulse `cpu_clk_en` is 0 and `per_clk_en` stays 1.
- R2: Two code-port writes with low nibbles 5h and then Ah arm the unlock. The upper nibbles are ignored. A following control write with bit 0 set then enters deep standby at the next `insn_bnd`, with `cpu_clk_en` and `per_clk_en` both 0.
- R3: A control write with bit 0 set and no valid unlock has no effect. This covers no code at all, a broken sequence such as 5h,3h,Ah, and a second deep-standby request after the first one used up the unlock. The clocks stay on after the next `insn_bnd`.
- R4: If control bit 2 was set on deep-standby entry, `port_hiz` is 1 from entry until the wake strobe. Otherwise it is 0.
- R5: If control bit 3 was set on entry, `osc_en` is 0 while in deep standby. If bit 3 was clear, `osc_en` stays 1.
- R6: With the oscillator stopped, control bits 5:4 (value k) select a delay of 2^(10+2k) cycles. The wake strobe comes 2^(10+2k)+1 cycles after the wake event is sampled, and `osc_en` is 1 during that wait. With the oscillator running, the strobe comes 1 cycle after the event.
- R7: `nmi` wakes either standby mode regardless of enables and the master enable, with `wake_kind`=01 (service).
- R8: A maskable request wakes only when some `irq_req[i]` and `irq_en[i]` are both 1. A request without its enable leaves the block in standby.
- R9: A maskable wake gives `wake_kind`=01 (service) if `mie` is 1 and 10 (resume at next instruction) if `mie` is 0.
- R10: `ext_rst_req` or `wdt_ovf` wakes the block with `wake_kind`=11 (reset processing). This code wins over any interrupt present in the same cycle.
- R11: `wake_vld` is a one-cycle pulse in the first cycle `cpu_clk_en` is 1 again.
- R12: After reset the block is running: `cpu_clk_en`=1, `per_clk_en`=1, `osc_en`=1, `port_hiz`=0, `wake_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctl | input | 1 | Control byte write strobe |
| wr_code | input | 1 | Unlock code write strobe |
| wr_data | input | 8 | Write data for either strobe |
| insn_bnd | input | 1 | Instruction boundary pulse from the core |
| irq_req | input | N_IRQ | Maskable interrupt request flags |
| irq_en | input | N_IRQ | Maskable interrupt enable flags |
| nmi | input | 1 | Non-maskable interrupt |
| mie | input | 1 | Master interrupt enable |
| ext_rst_req | input | 1 | Reset pin request |
| wdt_ovf | input | 1 | Watchdog overflow |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| port_hiz | output | 1 | Float output ports |
| wake_vld | output | 1 | Wake strobe |
| wake_kind | output | 2 | 01 service, 10 resume, 11 reset |

## Verification
Wake-up is tried from the light mode with five source patterns. A request without its enable must not wake. A request with its enable must give service or resume, depending on the master enable. A bare NMI must wake. A watchdog or pin reset is applied together with a pending interrupt to show which code wins. Deep-standby entry is tried with a correct unlock that uses non-zero upper nibbles, with a broken code sequence, with no code, and with a reused unlock, so that arming can be told apart from a plain request. Deep wakes are run with the oscillator kept on, with the shortest delay and with the longest delay, and the exact strobe cycle is checked to tell the stabilization path from the skip path.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_HALT_PEND, ST_HALT, ST_STOP_PEND, ST_STOP, ST_STAB
  } sby_state_e;

  localparam logic [1:0] WK_NONE    = 2'b00;
  localparam logic [1:0] WK_SERVICE = 2'b01;
  localparam logic [1:0] WK_RESUME  = 2'b10;
  localparam logic [1:0] WK_RESET   = 2'b11;

  localparam int CTL_STP = 0;
  localparam int CTL_HLT = 1;
  localparam int CTL_FLT = 2;
  localparam int CTL_OSC = 3;
  localparam int CTL_OST = 4;
endpackage

// File: rtl/stdby_unlock.sv
module stdby_unlock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_code,
  input  logic [3:0] code_nib,
  input  logic       consume,
  output logic       armed
);
  logic seen5_q, seen5_n, armed_q, armed_n;

  always_comb begin
    seen5_n = seen5_q;
    armed_n = armed_q;
    if (wr_code) begin
      if (code_nib == 4'h5) begin
        seen5_n = 1'b1;
        armed_n = 1'b0;
      end else if (code_nib == 4'hA && seen5_q) begin
        seen5_n = 1'b0;
        armed_n = 1'b1;
      end else begin
        seen5_n = 1'b0;
        armed_n = 1'b0;
      end
    end
    if (consume) armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen5_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      seen5_q <= seen5_n;
      armed_q <= armed_n;
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/stdby_wake_arb.sv
module stdby_wake_arb #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             nmi,
  input  logic             mie,
  input  logic             ext_rst_req,
  input  logic             wdt_ovf,
  output logic             hit,
  output logic [1:0]       kind
);
  import standby_pkg::*;

  logic [N_IRQ-1:0] pair_hit;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_pair
    assign pair_hit[g] = irq_req[g] & irq_en[g];
  end

  logic rst_src, mask_src;
  assign rst_src  = ext_rst_req | wdt_ovf;
  assign mask_src = |pair_hit;

  always_comb begin
    hit  = 1'b1;
    kind = WK_NONE;
    if (rst_src)       kind = WK_RESET;
    else if (nmi)      kind = WK_SERVICE;
    else if (mask_src) kind = mie ? WK_SERVICE : WK_RESUME;
    else               hit  = 1'b0;
  end
endmodule

// File: rtl/stdby_stab_timer.sv
module stdby_stab_timer #(
  parameter int BASE_LOG2 = 10,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n, term;
  logic             run_q, run_n;

  assign term = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + STEP_LOG2 * int'(sel));
  assign done = run_q && (cnt_q == term - 1'b1);

  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    if (start) begin
      cnt_n = '0;
      run_n = 1'b1;
    end else if (run_q) begin
      if (done) run_n = 1'b0;
      else      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end
endmodule

// File: rtl/standby_ctl.sv
module standby_ctl #(
  parameter int N_IRQ     = 4,
  parameter int BASE_LOG2 = 10,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_code,
  input  logic [7:0]       wr_data,
  input  logic             insn_bnd,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             nmi,
  input  logic             mie,
  input  logic             ext_rst_req,
  input  logic             wdt_ovf,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             port_hiz,
  output logic             wake_vld,
  output logic [1:0]       wake_kind
);
  import standby_pkg::*;

  sby_state_e state_q, state_n;
  logic       flt_q, flt_n, osc_off_q, osc_off_n;
  logic [1:0] ost_q, ost_n, kind_q, kind_n;
  logic       wv_q, wv_n;
  logic [1:0] wk_q, wk_n;
  logic       armed, stp_ok, wake_hit, tmr_start, tmr_done;
  logic [1:0] wake_code;
  logic       unused_hi;

  assign unused_hi = ^wr_data[7:6];
  assign stp_ok = (state_q == ST_RUN) && wr_ctl && wr_data[CTL_STP] && armed;

  stdby_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_code  (wr_code),
    .code_nib (wr_data[3:0]),
    .consume  (stp_ok),
    .armed    (armed)
  );

  stdby_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .nmi         (nmi),
    .mie         (mie),
    .ext_rst_req (ext_rst_req),
    .wdt_ovf     (wdt_ovf),
    .hit         (wake_hit),
    .kind        (wake_code)
  );

  stdby_stab_timer #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .SEL_W(2)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .sel   (ost_q),
    .done  (tmr_done)
  );

  always_comb begin
    state_n   = state_q;
    flt_n     = flt_q;
    osc_off_n = osc_off_q;
    ost_n     = ost_q;
    kind_n    = kind_q;
    wv_n      = 1'b0;
    wk_n      = wk_q;
    tmr_start = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (stp_ok) begin
          state_n   = ST_STOP_PEND;
          flt_n     = wr_data[CTL_FLT];
          osc_off_n = wr_data[CTL_OSC];
          ost_n     = wr_data[CTL_OST +: 2];
        end else if (wr_ctl && wr_data[CTL_HLT]) begin
          state_n = ST_HALT_PEND;
        end
      end
      ST_HALT_PEND: if (insn_bnd) state_n = ST_HALT;
      ST_STOP_PEND: if (insn_bnd) state_n = ST_STOP;
      ST_HALT: begin
        if (wake_hit) begin
          state_n = ST_RUN;
          wv_n    = 1'b1;
          wk_n    = wake_code;
        end
      end
      ST_STOP: begin
        if (wake_hit) begin
          if (osc_off_q) begin
            state_n   = ST_STAB;
            kind_n    = wake_code;
            tmr_start = 1'b1;
          end else begin
            state_n = ST_RUN;
            wv_n    = 1'b1;
            wk_n    = wake_code;
          end
        end
      end
      ST_STAB: begin
        if (tmr_done) begin
          state_n = ST_RUN;
          wv_n    = 1'b1;
          wk_n    = kind_q;
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      flt_q     <= 1'b0;
      osc_off_q <= 1'b0;
      ost_q     <= 2'b00;
      kind_q    <= WK_NONE;
      wv_q      <= 1'b0;
      wk_q      <= WK_NONE;
    end else begin
      state_q   <= state_n;
      flt_q     <= flt_n;
      osc_off_q <= osc_off_n;
      ost_q     <= ost_n;
      kind_q    <= kind_n;
      wv_q      <= wv_n;
      wk_q      <= wk_n;
    end
  end

  assign cpu_clk_en = (state_q == ST_RUN) || (state_q == ST_HALT_PEND) ||
                      (state_q == ST_STOP_PEND);
  assign per_clk_en = !((state_q == ST_STOP) || (state_q == ST_STAB));
  assign osc_en     = !((state_q == ST_STOP) && osc_off_q);
  assign port_hiz   = flt_q && ((state_q == ST_STOP) || (state_q == ST_STAB));
  assign wake_vld   = wv_q;
  assign wake_kind  = wk_q;
endmodule

// File: rtl/standby_ctl_chk.sv
module standby_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_bnd,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_en,
  input logic       port_hiz,
  input logic       wake_vld,
  input logic [1:0] wake_kind
);
  // R1: the CPU clock only drops after an instruction boundary
  assert_gate_at_bnd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> $past(insn_bnd));

  // R2: peripheral clock off implies CPU clock off
  assert_per_off_cpu_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> !cpu_clk_en);

  // R5: oscillator off only in deep standby
  assert_osc_off_deep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!per_clk_en && !cpu_clk_en));

  // R4: ports float only while the clocks are gated
  assert_hiz_only_deep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    port_hiz |-> !per_clk_en);

  // R11: wake strobe is a single cycle coinciding with clock return
  assert_wake_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vld |=> !wake_vld);
  assert_wake_with_clk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vld |-> ($rose(cpu_clk_en) && wake_kind != 2'b00));
endmodule

bind standby_ctl standby_ctl_chk chk_i (.*);

// File: tb/standby_ctl_tb.sv
module standby_ctl_tb_top;
  localparam int N = 4;

  logic         clk, rst_n;
  logic         wr_ctl, wr_code, insn_bnd, nmi, mie, ext_rst_req, wdt_ovf;
  logic [7:0]   wr_data;
  logic [N-1:0] irq_req, irq_en;
  logic         cpu_clk_en, per_clk_en, osc_en, port_hiz, wake_vld;
  logic [1:0]   wake_kind;

  standby_ctl #(.N_IRQ(N)) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [1:0] kind;
    int         at;
    string      req;
  } exp_t;
  exp_t q[$];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected wake items as the design signals them
  always @(negedge clk) begin
    if (rst_n && wake_vld) begin
      if (q.size() == 0) begin
        check("R8 unexpected wake", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.req, " kind"}, int'(wake_kind), int'(e.kind));
        check({e.req, " cycle"}, cyc, e.at);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input logic [7:0] d);
    @(negedge clk); wr_ctl = 1'b1; wr_data = d;
    @(negedge clk); wr_ctl = 1'b0;
  endtask

  task automatic code(input logic [7:0] d);
    @(negedge clk); wr_code = 1'b1; wr_data = d;
    @(negedge clk); wr_code = 1'b0;
  endtask

  task automatic bnd();
    @(negedge clk); insn_bnd = 1'b1;
    @(negedge clk); insn_bnd = 1'b0;
  endtask

  // driver: applies one wake pattern for a cycle, pushing the expected item
  task automatic fire(input logic [N-1:0] rq, input logic [N-1:0] en,
                      input logic n, input logic m, input logic er,
                      input logic wd, input logic expect_it,
                      input logic [1:0] kind, input int delay, input string req);
    @(negedge clk);
    irq_req = rq; irq_en = en; nmi = n; mie = m; ext_rst_req = er; wdt_ovf = wd;
    if (expect_it) q.push_back('{kind, cyc + 1 + delay, req});
    @(negedge clk);
    irq_req = '0; irq_en = '0; nmi = 1'b0; ext_rst_req = 1'b0; wdt_ovf = 1'b0;
  endtask

  task automatic enter_halt();
    ctl(8'h02);
    check("R1 cpu before boundary", int'(cpu_clk_en), 1);
    bnd();
    check("R1 cpu gated", int'(cpu_clk_en), 0);
    check("R1 per running", int'(per_clk_en), 1);
  endtask

  task automatic run_tests();
    wr_ctl = 0; wr_code = 0; wr_data = '0; insn_bnd = 0; irq_req = '0; irq_en = '0;
    nmi = 0; mie = 0; ext_rst_req = 0; wdt_ovf = 0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R12 cpu", int'(cpu_clk_en), 1);
    check("R12 per", int'(per_clk_en), 1);
    check("R12 osc", int'(osc_en), 1);
    check("R12 hiz", int'(port_hiz), 0);
    check("R12 wake", int'(wake_vld), 0);

    // maskable without enable must not wake, then with enable and mie=1
    enter_halt();
    fire(4'b0100, 4'b1011, 0, 1, 0, 0, 0, 2'b00, 0, "R8");
    tick(3);
    check("R8 no wake", int'(cpu_clk_en), 0);
    fire(4'b0100, 4'b0100, 0, 1, 0, 0, 1, 2'b01, 0, "R9 service");
    check("R11 strobe with clock", int'(wake_vld && cpu_clk_en), 1);
    tick(1);
    check("R11 strobe one cycle", int'(wake_vld), 0);

    enter_halt();
    fire(4'b0001, 4'b0001, 0, 0, 0, 0, 1, 2'b10, 0, "R9 resume");
    tick(2);

    enter_halt();
    fire(4'b0000, 4'b0000, 1, 0, 0, 0, 1, 2'b01, 0, "R7 nmi");
    tick(2);

    enter_halt();
    fire(4'b1000, 4'b1000, 1, 1, 0, 1, 1, 2'b11, 0, "R10 watchdog");
    tick(2);
    enter_halt();
    fire(4'b0000, 4'b0000, 0, 0, 1, 0, 1, 2'b11, 0, "R10 pin");
    tick(2);

    // deep request without unlock, with broken code, with lone Ah
    ctl(8'h01); bnd();
    check("R3 no code", int'(per_clk_en && cpu_clk_en), 1);
    code(8'h05); code(8'h03); code(8'h0A);
    ctl(8'h01); bnd();
    check("R3 broken code", int'(per_clk_en && cpu_clk_en), 1);
    code(8'h0A);
    ctl(8'h01); bnd();
    check("R3 lone A", int'(per_clk_en && cpu_clk_en), 1);

    // deep standby, oscillator kept running, ports floated
    code(8'h75); code(8'hFA);
    ctl(8'h05);
    check("R2 pending cpu", int'(cpu_clk_en), 1);
    bnd();
    check("R2 cpu gated", int'(cpu_clk_en), 0);
    check("R2 per gated", int'(per_clk_en), 0);
    check("R5 osc kept", int'(osc_en), 1);
    check("R4 hiz on", int'(port_hiz), 1);
    fire(4'b0000, 4'b0000, 1, 0, 0, 0, 1, 2'b01, 0, "R6 skip delay");
    check("R4 hiz released", int'(port_hiz), 0);
    tick(2);

    // unlock already consumed
    ctl(8'h01); bnd();
    check("R3 reused unlock", int'(per_clk_en), 1);

    // oscillator stopped, shortest delay
    code(8'h05); code(8'h0A);
    ctl(8'h09); bnd();
    check("R5 osc stopped", int'(osc_en), 0);
    check("R4 hiz off", int'(port_hiz), 0);
    fire(4'b0010, 4'b0010, 0, 1, 0, 0, 1, 2'b01, 1024, "R6 delay k0");
    check("R6 osc during wait", int'(osc_en), 1);
    check("R6 cpu during wait", int'(cpu_clk_en), 0);
    tick(1030);

    // oscillator stopped, longest delay, floated, resume
    code(8'h35); code(8'hCA);
    ctl(8'h3D); bnd();
    check("R5 osc stopped k3", int'(osc_en), 0);
    fire(4'b0001, 4'b0001, 0, 0, 0, 0, 1, 2'b10, 65536, "R6 delay k3");
    check("R4 hiz during wait", int'(port_hiz), 1);
    tick(65540);
    check("R6 all wakes seen", q.size(), 0);
    check("R6 running", int'(cpu_clk_en && per_clk_en && osc_en), 1);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule